// File: doc/BRIEF.md
# Low-Power Entry Sequencer

This block takes a small processor subsystem into one of three sleep levels and brings it back out. The processor signals a wait-for-interrupt with a one-cycle strobe. At that moment the block latches a two-bit level selector. It then waits for the non-volatile memory to report that it is ready. Once ready, it commits to the chosen level and drives the clock-gate enables for the CPU, for each bus peripheral that can request its clock, and for one special bus peripheral that has no request line. It also drives two low-power outputs, one for the regulator and one for the SRAM.

While asleep, the block watches three kinds of interrupt line. Asynchronous lines always wake it. Synchronous lines wake it in the idle levels. In standby, a synchronous line wakes it only when that line's run-in-standby qualifier is set. On a qualified wake the block spends one cycle in a wake state. In that cycle every clock is on, both low-power outputs are normal, and a wake pulse is raised. The block then returns to the active state.

Top module: `sleep_seq`

## Requirements
- R1: After reset, the block is active. The CPU enable, every bus enable and the special enable are all 1. The sleeping, wake, regulator low-power and SRAM low-power outputs are 0, and the level output is 2'b00.
- R2: The level selector is encoded as 2'b00 = IDLE0, 2'b10 = IDLE2 and 2'b11 = STANDBY. A strobe sampled in the active state with one of these values moves the block to a pending state. The block commits at the first later edge where the memory ready flag is sampled as 1. The sleeping output rises after that edge, so it cannot rise earlier than two edges after the strobe. While pending, all clocks stay on.
- R3: A strobe with the reserved selector value 2'b01 is ignored. The block stays active, with all clocks on and the sleeping output at 0.
- R4: The CPU clock enable is 0 while asleep at any level.
- R5: Asleep in IDLE0, each bus enable equals that peripheral's clock request, and the special enable is 1.
- R6: Asleep in IDLE2, each bus enable equals that peripheral's clock request, and the special enable is 0.
- R7: Asleep in STANDBY, each bus enable equals that peripheral's clock request, and the special enable is 0.
- R8: In IDLE0 and IDLE2, any synchronous or asynchronous interrupt line at 1 causes a wake.
- R9: In STANDBY, an asynchronous line causes a wake. A synchronous line causes a wake only if its run-in-standby bit is 1; otherwise it is ignored and the block stays asleep.
- R10: Asleep in STANDBY, the regulator low-power output equals the regulator-mode setting and the SRAM low-power output equals the SRAM bias setting. In the idle levels, both outputs are 0.
- R11: One edge after a qualifying interrupt is sampled, the wake output is 1 for exactly one cycle. In that cycle all clock enables are 1, both low-power outputs are 0, and the sleeping output is 0. The block is active on the following cycle.
- R12: While asleep, the level output shows the committed level. Otherwise it shows 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wfi_i | input | 1 | Wait-for-interrupt strobe |
| level_sel_i | input | 2 | Requested sleep level |
| nvm_ready_i | input | 1 | Non-volatile memory ready flag |
| stby_reg_lp_i | input | 1 | Regulator low-power setting for standby |
| stby_sram_lp_i | input | 1 | SRAM bias setting for standby |
| clk_req_i | input | NP | Per-peripheral bus clock requests |
| sync_irq_i | input | NS | Synchronous interrupt lines |
| sync_rstby_i | input | NS | Run-in-standby qualifier per synchronous line |
| async_irq_i | input | NA | Asynchronous interrupt lines |
| cpu_clk_en_o | output | 1 | CPU clock gate enable |
| bus_clk_en_o | output | NP | Per-peripheral bus clock gate enables |
| spec_clk_en_o | output | 1 | Gate enable for the peripheral without a request line |
| reg_lp_o | output | 1 | Regulator low-power select |
| sram_lp_o | output | 1 | SRAM low-power select |
| wake_o | output | 1 | One-cycle wake pulse |
| sleeping_o | output | 1 | High while committed to a sleep level |
| level_o | output | 2 | Committed level while asleep |

## Verification
The assertions check several rules on every cycle:
- the sleeping output can only rise after the memory ready flag was sampled high;
- the wake pulse never lasts longer than one cycle, and it always follows a sleep period;
- no bus enable is ever granted without a request while asleep;
- the special peripheral is gated in IDLE2 and STANDBY;
- the low-power outputs stay normal outside standby;
- a reserved selector is ignored.

Only the bench scenarios can show the following:
- which interrupt mixes wake the block in each level, and which ones are ignored in standby;
- that the low-power outputs follow the two settings;
- that the pending state can last for several cycles.

// File: rtl/sleep_pkg.sv
// Shared types for the low-power entry sequencer.
// Assumes a two-bit level selector with one reserved code.
package sleep_pkg;

    typedef enum logic [1:0] {
        LVL_IDLE0 = 2'b00,
        LVL_RSVD  = 2'b01,
        LVL_IDLE2 = 2'b10,
        LVL_STBY  = 2'b11
    } sleep_lvl_e;

    typedef enum logic [1:0] {
        ST_ACTIVE = 2'b00,
        ST_PEND   = 2'b01,
        ST_SLEEP  = 2'b10,
        ST_WAKE   = 2'b11
    } seq_state_e;

endpackage

// File: rtl/sleep_fsm.sv
// Sequencer state machine: active -> pending -> asleep -> wake -> active.
// Assumes wfi_i is a one-cycle strobe and wake_req is already qualified.
module sleep_fsm
    import sleep_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wfi,
    input  logic [1:0] level_sel,
    input  logic       nvm_ready,
    input  logic       wake_req,
    output seq_state_e state,
    output logic [1:0] level
);

    seq_state_e state_q, state_d;
    logic [1:0] level_q, level_d;
    logic       sel_ok;

    // Decide whether the selector holds a legal level code.
    always_comb begin
        sel_ok = (level_sel != LVL_RSVD);
    end

    // Next-state and level-capture logic.
    always_comb begin
        state_d = state_q;
        level_d = level_q;
        unique case (state_q)
            ST_ACTIVE: if (wfi && sel_ok) begin
                state_d = ST_PEND;
                level_d = level_sel;
            end
            ST_PEND:   if (nvm_ready) state_d = ST_SLEEP;
            ST_SLEEP:  if (wake_req)  state_d = ST_WAKE;
            ST_WAKE:   state_d = ST_ACTIVE;
            default:   state_d = ST_ACTIVE;
        endcase
    end

    // State and level registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_ACTIVE;
            level_q <= LVL_IDLE0;
        end else begin
            state_q <= state_d;
            level_q <= level_d;
        end
    end

    assign state = state_q;
    assign level = level_q;

    AST_RSVD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACTIVE && wfi && level_sel == LVL_RSVD) |=> (state_q == ST_ACTIVE)); // R3
    AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PEND && !nvm_ready) |=> (state_q == ST_PEND)); // R2
    AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAKE) |=> (state_q == ST_ACTIVE)); // R11

endmodule

// File: rtl/sleep_wake_qual.sv
// Wake qualifier: combines interrupt lines according to the committed level.
// Assumes interrupt inputs are already synchronised to clk.
module sleep_wake_qual
    import sleep_pkg::*;
#(
    parameter int NS = 4,
    parameter int NA = 2
) (
    input  logic [1:0]    level,
    input  logic [NS-1:0] sync_irq,
    input  logic [NS-1:0] sync_rstby,
    input  logic [NA-1:0] async_irq,
    output logic          wake_req
);

    logic [NS-1:0] sync_ok;

    // Mask synchronous lines in standby to those allowed to run there.
    always_comb begin
        if (level == LVL_STBY) sync_ok = sync_irq & sync_rstby;
        else                   sync_ok = sync_irq;
    end

    // Any asynchronous line or any surviving synchronous line wakes.
    always_comb begin
        wake_req = (|async_irq) | (|sync_ok);
    end

endmodule

// File: rtl/sleep_gate_ctrl.sv
// Output decode: clock gate enables, low-power selects and status.
// Assumes the downstream gating cells tolerate enables driven from state.
module sleep_gate_ctrl
    import sleep_pkg::*;
#(
    parameter int NP = 4
) (
    input  seq_state_e    state,
    input  logic [1:0]    level,
    input  logic [NP-1:0] clk_req,
    input  logic          stby_reg_lp,
    input  logic          stby_sram_lp,
    output logic          cpu_clk_en,
    output logic [NP-1:0] bus_clk_en,
    output logic          spec_clk_en,
    output logic          reg_lp,
    output logic          sram_lp,
    output logic          wake,
    output logic          sleeping,
    output logic [1:0]    level_out
);

    logic asleep;
    logic in_stby;

    // Decode the sleeping condition and the standby level.
    always_comb begin
        asleep  = (state == ST_SLEEP);
        in_stby = asleep && (level == LVL_STBY);
    end

    // Clock gate enables: all on unless committed to a level.
    always_comb begin
        cpu_clk_en  = !asleep;
        bus_clk_en  = asleep ? clk_req : {NP{1'b1}};
        spec_clk_en = !asleep || (level == LVL_IDLE0);
    end

    // Low-power selects and status outputs.
    always_comb begin
        reg_lp    = in_stby && stby_reg_lp;
        sram_lp   = in_stby && stby_sram_lp;
        wake      = (state == ST_WAKE);
        sleeping  = asleep;
        level_out = asleep ? level : 2'b00;
    end

endmodule

// File: rtl/sleep_seq.sv
// Top of the low-power entry sequencer. It ties the state machine, the
// wake qualifier and the output decode together. Assumes all inputs are
// synchronous to clk.
module sleep_seq #(
    parameter int NP = 4,
    parameter int NS = 4,
    parameter int NA = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wfi_i,
    input  logic [1:0]    level_sel_i,
    input  logic          nvm_ready_i,
    input  logic          stby_reg_lp_i,
    input  logic          stby_sram_lp_i,
    input  logic [NP-1:0] clk_req_i,
    input  logic [NS-1:0] sync_irq_i,
    input  logic [NS-1:0] sync_rstby_i,
    input  logic [NA-1:0] async_irq_i,
    output logic          cpu_clk_en_o,
    output logic [NP-1:0] bus_clk_en_o,
    output logic          spec_clk_en_o,
    output logic          reg_lp_o,
    output logic          sram_lp_o,
    output logic          wake_o,
    output logic          sleeping_o,
    output logic [1:0]    level_o
);

    sleep_pkg::seq_state_e state;
    logic [1:0]            level;
    logic                  wake_req;

    sleep_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wfi       (wfi_i),
        .level_sel (level_sel_i),
        .nvm_ready (nvm_ready_i),
        .wake_req  (wake_req),
        .state     (state),
        .level     (level)
    );

    sleep_wake_qual #(.NS(NS), .NA(NA)) u_qual (
        .level      (level),
        .sync_irq   (sync_irq_i),
        .sync_rstby (sync_rstby_i),
        .async_irq  (async_irq_i),
        .wake_req   (wake_req)
    );

    sleep_gate_ctrl #(.NP(NP)) u_gate (
        .state        (state),
        .level        (level),
        .clk_req      (clk_req_i),
        .stby_reg_lp  (stby_reg_lp_i),
        .stby_sram_lp (stby_sram_lp_i),
        .cpu_clk_en   (cpu_clk_en_o),
        .bus_clk_en   (bus_clk_en_o),
        .spec_clk_en  (spec_clk_en_o),
        .reg_lp       (reg_lp_o),
        .sram_lp      (sram_lp_o),
        .wake         (wake_o),
        .sleeping     (sleeping_o),
        .level_out    (level_o)
    );

    AST_ENTRY_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleeping_o) |-> $past(nvm_ready_i)); // R2
    AST_WAKE_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |=> (!wake_o && !sleeping_o)); // R11
    AST_EXIT_VIA_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sleeping_o) |-> wake_o); // R11
    AST_CPU_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        sleeping_o |-> !cpu_clk_en_o); // R4
    AST_NO_UNREQ_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        sleeping_o |-> ((bus_clk_en_o & ~clk_req_i) == '0)); // R7
    AST_SPEC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (sleeping_o && level_o != 2'b00) |-> !spec_clk_en_o); // R6
    AST_LP_NORMAL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (level_o != 2'b11) |-> (!reg_lp_o && !sram_lp_o)); // R10

endmodule

// File: tb/sleep_seq_tb.sv
`timescale 1ns/1ps
module sleep_seq_tb;

    localparam int NP = 4;
    localparam int NS = 4;
    localparam int NA = 2;
    localparam int NV = 8;

    // Vector layout: {sel[2], req[4], sync[4], rstby[4], async[2], regc, sramc,
    //                 exp_spec, exp_reg, exp_sram, exp_wake}
    localparam logic [21:0] VEC [NV] = '{
        22'b00_1010_0001_0000_00_1_1_1_0_0_1,
        22'b00_0000_0000_0000_01_0_0_1_0_0_1,
        22'b10_0110_0100_0000_00_1_0_0_0_0_1,
        22'b10_1111_0000_0000_10_0_1_0_0_0_1,
        22'b11_0011_0010_0000_00_1_1_0_1_1_0,
        22'b11_1000_0010_0010_00_1_0_0_1_0_1,
        22'b11_0000_0000_0000_01_0_1_0_0_1_1,
        22'b11_0101_1000_0111_00_0_0_0_0_0_0
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          wfi_i;
    logic [1:0]    level_sel_i;
    logic          nvm_ready_i;
    logic          stby_reg_lp_i;
    logic          stby_sram_lp_i;
    logic [NP-1:0] clk_req_i;
    logic [NS-1:0] sync_irq_i;
    logic [NS-1:0] sync_rstby_i;
    logic [NA-1:0] async_irq_i;
    logic          cpu_clk_en_o;
    logic [NP-1:0] bus_clk_en_o;
    logic          spec_clk_en_o;
    logic          reg_lp_o;
    logic          sram_lp_o;
    logic          wake_o;
    logic          sleeping_o;
    logic [1:0]    level_o;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    sleep_seq #(.NP(NP), .NS(NS), .NA(NA)) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .wfi_i          (wfi_i),
        .level_sel_i    (level_sel_i),
        .nvm_ready_i    (nvm_ready_i),
        .stby_reg_lp_i  (stby_reg_lp_i),
        .stby_sram_lp_i (stby_sram_lp_i),
        .clk_req_i      (clk_req_i),
        .sync_irq_i     (sync_irq_i),
        .sync_rstby_i   (sync_rstby_i),
        .async_irq_i    (async_irq_i),
        .cpu_clk_en_o   (cpu_clk_en_o),
        .bus_clk_en_o   (bus_clk_en_o),
        .spec_clk_en_o  (spec_clk_en_o),
        .reg_lp_o       (reg_lp_o),
        .sram_lp_o      (sram_lp_o),
        .wake_o         (wake_o),
        .sleeping_o     (sleeping_o),
        .level_o        (level_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic awake_all_on(input string tag);
        chk(tag, {31'd0, cpu_clk_en_o}, 32'd1);
        chk(tag, {28'd0, bus_clk_en_o}, 32'hF);
        chk(tag, {31'd0, spec_clk_en_o}, 32'd1);
        chk(tag, {31'd0, sleeping_o}, 32'd0);
        chk(tag, {30'd0, reg_lp_o, sram_lp_o}, 32'd0);
    endtask

    // Pulse an asynchronous line to leave sleep, then return to active.
    task automatic force_exit();
        sync_irq_i  = '0;
        async_irq_i = 2'b01;
        step();
        chk("R11 wake pulse", {31'd0, wake_o}, 32'd1);
        async_irq_i = '0;
        step();
        chk("R11 back active", {31'd0, wake_o}, 32'd0);
    endtask

    initial begin
        rst_n = 1'b0; wfi_i = 1'b0; level_sel_i = 2'b00; nvm_ready_i = 1'b1;
        stby_reg_lp_i = 1'b0; stby_sram_lp_i = 1'b0; clk_req_i = '0;
        sync_irq_i = '0; sync_rstby_i = '0; async_irq_i = '0;
        @(negedge clk);
        step();
        // R1 reset state
        awake_all_on("R1 reset");
        chk("R1 wake", {31'd0, wake_o}, 32'd0);
        chk("R1 level", {30'd0, level_o}, 32'd0);
        rst_n = 1'b1;
        step();

        // Table walk
        for (int i = 0; i < NV; i++) begin
            logic [21:0] v;
            string bt;
            string wt;
            v = VEC[i];
            bt = (v[21:20] == 2'b00) ? "R5 bus" : (v[21:20] == 2'b10) ? "R6 bus" : "R7 bus";
            wt = (v[21:20] == 2'b11) ? "R9 wake" : "R8 wake";
            clk_req_i = v[19:16]; stby_reg_lp_i = v[5]; stby_sram_lp_i = v[4];
            wfi_i = 1'b1; level_sel_i = v[21:20];
            step();
            wfi_i = 1'b0;
            chk("R2 pending", {31'd0, sleeping_o}, 32'd0);
            chk("R2 pending cpu", {31'd0, cpu_clk_en_o}, 32'd1);
            step();
            chk("R2 asleep", {31'd0, sleeping_o}, 32'd1);
            chk("R4 cpu off", {31'd0, cpu_clk_en_o}, 32'd0);
            chk(bt, {28'd0, bus_clk_en_o}, {28'd0, v[19:16]});
            chk(bt, {31'd0, spec_clk_en_o}, {31'd0, v[3]});
            chk("R10 reg lp", {31'd0, reg_lp_o}, {31'd0, v[2]});
            chk("R10 sram lp", {31'd0, sram_lp_o}, {31'd0, v[1]});
            chk("R12 level", {30'd0, level_o}, {30'd0, v[21:20]});
            sync_irq_i = v[15:12]; sync_rstby_i = v[11:8]; async_irq_i = v[7:6];
            step();
            if (v[0]) begin
                chk(wt, {31'd0, wake_o}, 32'd1);
                awake_all_on("R11 wake cycle");
                chk("R12 level idle", {30'd0, level_o}, 32'd0);
                sync_irq_i = '0; async_irq_i = '0;
                step();
                chk("R11 pulse ends", {31'd0, wake_o}, 32'd0);
                chk("R11 active cpu", {31'd0, cpu_clk_en_o}, 32'd1);
            end else begin
                chk(wt, {31'd0, wake_o}, 32'd0);
                chk("R9 still asleep", {31'd0, sleeping_o}, 32'd1);
                force_exit();
            end
            sync_rstby_i = '0;
            step();
        end

        // R3 reserved selector
        wfi_i = 1'b1; level_sel_i = 2'b01;
        step();
        wfi_i = 1'b0;
        step();
        step();
        chk("R3 reserved", {31'd0, sleeping_o}, 32'd0);
        awake_all_on("R3 clocks on");

        // R2 entry held off by memory not ready
        nvm_ready_i = 1'b0; clk_req_i = 4'b0001;
        wfi_i = 1'b1; level_sel_i = 2'b10;
        step();
        wfi_i = 1'b0;
        for (int k = 0; k < 3; k++) begin
            step();
            chk("R2 held pending", {31'd0, sleeping_o}, 32'd0);
            chk("R2 held cpu", {31'd0, cpu_clk_en_o}, 32'd1);
        end
        nvm_ready_i = 1'b1;
        step();
        chk("R2 commit", {31'd0, sleeping_o}, 32'd1);
        chk("R12 level idle2", {30'd0, level_o}, 32'd2);
        force_exit();

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        done = 1'b1;
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule